// File: doc/BRIEF.md
# Filtered External Event Counter

This block counts transitions on an external pin that is not related to the internal clock. The pin first passes through a chain of synchronizing flops. It then goes through a digital filter, which accepts a new level only after that level has been seen on two consecutive samples. Finally, an edge detector uses a two-bit selector to decide whether rising transitions, falling transitions or both advance the 16-bit count.

Software sets up the block in a fixed order. It chooses the edge polarity, loads a nonzero compare value, and then raises the run enable. When the count reaches the compare value, the block clears the counter to zero on the next clock. In that same cycle, it raises a single-cycle interrupt pulse. A compare value of zero is not a legal setting, so the counter stays at zero while it is programmed. Dropping the run enable also parks the counter at zero. The reset input is asynchronous and active low. It is released inside the block in step with the clock.

Top module: `evc_event_counter`

## Requirements
- R1: While reset is asserted, and for as long as nothing has been counted after it, the count reads 0 and the interrupt is low.
- R2: With edge_sel = 2'b01, each filtered low-to-high transition on the pin adds one to the count, and high-to-low transitions leave it unchanged.
- R3: With edge_sel = 2'b00, each filtered high-to-low transition adds one, and low-to-high transitions leave it unchanged.
- R4: With edge_sel = 2'b11, every filtered transition in either direction adds one.
- R5: With edge_sel = 2'b10, no transition changes the count.
- R6: A pin pulse lasting one clock period is discarded as noise and never counted. A pulse of two clock periods or longer is accepted.
- R7: When the count equals a nonzero compare value while running, the next clock sets the count to 0. The interrupt is high for exactly that one cycle.
- R8: While the compare value is 0, the count is held at 0 and no interrupt is raised, whatever the pin does.
- R9: While run is low, the count is held at 0 and no interrupt is raised. After run is raised again, counting restarts from 0 and no interrupt is produced by the restart.
- R10: If the compare value is lowered below the current count, counting continues. The count rolls over from 0xFFFF to 0 without an interrupt, and then matches the new value on the following pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Count enable; low holds the counter at 0 |
| edge_sel | input | 2 | Counted transition: 00 falling, 01 rising, 10 none, 11 both |
| cmp | input | 16 | Compare value; 0 keeps the counter idle |
| pin | input | 1 | Raw asynchronous external input |
| count | output | 16 | Current count value |
| irq | output | 1 | One-cycle pulse when the counter clears on a match |

## Verification
The assertions check the following on every cycle:
- the count only ever steps up by one or returns to zero;
- the interrupt lasts one cycle and coincides with a zero count;
- a disabled run or a zero compare value forces the counter to zero;
- the reserved selector never lets the count advance;
- the filtered level changes only after two agreeing samples.

Only the directed scenarios can show the rest:
- that each polarity counts the right transitions and ignores the others;
- that a one-period glitch is rejected while a two-period pulse counts;
- the exact cycle in which the match clears the counter;
- the long rollover past 0xFFFF when the compare value is lowered beneath the count.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned EVC_CNT_W    = 16;
  localparam int unsigned EVC_SYNC_STG = 2;
  localparam int unsigned EVC_FILT_SMP = 2;

endpackage

// File: rtl/evc_rst_sync.sv
module evc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_nxt;

  always_comb begin
    stg_nxt = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_nxt;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/evc_filter.sv
module evc_filter #(
  parameter int unsigned SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_in,
  output logic lvl_out
);

  localparam int unsigned HW = SAMPLES - 1;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_nxt;
  logic          lvl_q;
  logic          lvl_nxt;
  logic          agree_hi;
  logic          agree_lo;
  logic          lvl_en;

  generate
    if (SAMPLES == 2) begin : g_hist1
      always_comb hist_nxt = smp_in;
    end else begin : g_histn
      always_comb hist_nxt = {hist_q[HW-2:0], smp_in};
    end
  endgenerate

  always_comb begin
    agree_hi = &{smp_in, hist_q};
    agree_lo = ~|{smp_in, hist_q};
    lvl_en   = (agree_hi & ~lvl_q) | (agree_lo & lvl_q);
    lvl_nxt  = agree_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (lvl_en) begin
      lvl_q <= lvl_nxt;
    end
  end

  assign lvl_out = lvl_q;

  AST_FILTER_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (($past(smp_in) == lvl_q) && ($past(hist_q[0]) == lvl_q))); // R6

endmodule

// File: rtl/evc_edge.sv
module evc_edge
  import evc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] mode,
  output logic       evt
);

  logic prev_q;
  logic rise;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl;
    end
  end

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    case (edge_sel_e'(mode))
      EDGE_FALL: evt = fall;
      EDGE_RISE: evt = rise;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  AST_NONE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_NONE) |-> !evt); // R5

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         evt,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         irq
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;
  logic         active;
  logic         match;
  logic         irq_q;

  always_comb begin
    active = run && (cmp != '0);
    match  = active && (cnt_q == cmp);
    if (!active) begin
      cnt_nxt = '0;
      cnt_en  = (cnt_q != '0);
    end else if (match) begin
      cnt_nxt = '0;
      cnt_en  = 1'b1;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
      cnt_en  = evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= match;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;

  AST_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0))); // R2
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R7
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == '0)); // R7
  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cmp != '0) && (cnt_q == cmp)) |=> ((cnt_q == '0) && irq_q)); // R7
  AST_ZERO_CMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |=> ((cnt_q == '0) && !irq_q)); // R8
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((cnt_q == '0) && !irq_q)); // R9

endmodule

// File: rtl/evc_event_counter.sv
module evc_event_counter
  import evc_pkg::*;
#(
  parameter int unsigned CNT_W        = EVC_CNT_W,
  parameter int unsigned SYNC_STAGES  = EVC_SYNC_STG,
  parameter int unsigned FILT_SAMPLES = EVC_FILT_SMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] cmp,
  input  logic             pin,
  output logic [CNT_W-1:0] count,
  output logic             irq
);

  logic rst_n_s;
  logic pin_s;
  logic pin_f;
  logic evt;

  evc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   (pin),
    .dout  (pin_s)
  );

  evc_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .smp_in  (pin_s),
    .lvl_out (pin_f)
  );

  evc_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n_s),
    .lvl   (pin_f),
    .mode  (edge_sel),
    .evt   (evt)
  );

  evc_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run   (run),
    .evt   (evt),
    .cmp   (cmp),
    .cnt   (count),
    .irq   (irq)
  );

  AST_NONE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((count != $past(count)) && (count != '0)) |-> ($past(edge_sel) != EDGE_NONE)); // R5

endmodule

// File: tb/evc_event_counter_tb.sv
module evc_event_counter_tb;

  logic        clk;
  logic        rst_n;
  logic        run;
  logic [1:0]  edge_sel;
  logic [15:0] cmp;
  logic        pin;
  logic [15:0] count;
  logic        irq;

  int checks;
  int errors;
  int irq_seen;
  bit finished;

  evc_event_counter u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .edge_sel (edge_sel),
    .cmp      (cmp),
    .pin      (pin),
    .count    (count),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk) pin = 1'b1;
    repeat (hi) @(negedge clk);
    pin = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pin = ~pin;
      @(negedge clk);
    end
  endtask

  task automatic restart(input logic [1:0] m, input logic [15:0] c);
    @(negedge clk) run = 1'b0; edge_sel = m; cmp = c;
    repeat (2) @(negedge clk);
    run = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run = 1'b0; edge_sel = 2'b01; cmp = 16'd100; pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 count in reset", count, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    settle();
    chk("R1 count after reset", count, 0);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_rising();
    restart(2'b01, 16'd100);
    pulse(3, 5); pulse(3, 5);
    settle();
    chk("R2 two rising", count, 2);
    @(negedge clk) pin = 1'b1;
    settle();
    chk("R2 rise counted", count, 3);
    @(negedge clk) pin = 1'b0;
    settle();
    chk("R2 fall ignored", count, 3);
  endtask

  task automatic t_falling();
    restart(2'b00, 16'd100);
    chk("R9 cleared by stop", count, 0);
    @(negedge clk) pin = 1'b1;
    settle();
    chk("R3 rise ignored", count, 0);
    @(negedge clk) pin = 1'b0;
    settle();
    chk("R3 fall counted", count, 1);
  endtask

  task automatic t_both();
    restart(2'b11, 16'd100);
    pulse(3, 5); pulse(4, 6);
    settle();
    chk("R4 both edges", count, 4);
  endtask

  task automatic t_none();
    restart(2'b01, 16'd100);
    pulse(3, 5);
    settle();
    @(negedge clk) edge_sel = 2'b10;
    pulse(3, 5); pulse(3, 5);
    settle();
    chk("R5 reserved no count", count, 1);
  endtask

  task automatic t_filter();
    restart(2'b11, 16'd100);
    pulse(1, 6); pulse(1, 6);
    settle();
    chk("R6 glitch rejected", count, 0);
    pulse(2, 6);
    settle();
    chk("R6 two-sample pulse", count, 2);
  endtask

  task automatic t_match();
    int base;
    int n;
    restart(2'b01, 16'd3);
    base = irq_seen;
    pulse(3, 5); pulse(3, 5);
    settle();
    chk("R7 below compare", count, 2);
    @(negedge clk) pin = 1'b1;
    n = 0;
    while (count != 16'd3 && n < 12) begin
      @(negedge clk);
      n++;
    end
    chk("R7 reached compare", count, 3);
    chk("R7 no irq yet", irq, 0);
    @(negedge clk);
    chk("R7 cleared next cycle", count, 0);
    chk("R7 irq high", irq, 1);
    @(negedge clk);
    chk("R7 irq one cycle", irq, 0);
    pin = 1'b0;
    settle();
    chk("R7 single irq", irq_seen - base, 1);
  endtask

  task automatic t_zero_cmp();
    int base;
    restart(2'b11, 16'd0);
    base = irq_seen;
    pulse(3, 5); pulse(3, 5);
    settle();
    chk("R8 zero compare idle", count, 0);
    chk("R8 zero compare no irq", irq_seen - base, 0);
  endtask

  task automatic t_run();
    int base;
    restart(2'b11, 16'd2);
    base = irq_seen;
    @(negedge clk) run = 1'b0;
    pulse(3, 5);
    settle();
    chk("R9 stopped holds 0", count, 0);
    @(negedge clk) run = 1'b1;
    settle();
    chk("R9 restart at 0", count, 0);
    chk("R9 restart no irq", irq_seen - base, 0);
    @(negedge clk) pin = 1'b1;
    settle();
    chk("R9 counts after restart", count, 1);
    @(negedge clk) pin = 1'b0;
    settle();
  endtask

  task automatic t_wrap();
    int base;
    restart(2'b11, 16'd40000);
    toggle(10);
    settle();
    chk("R10 preload", count, 10);
    @(negedge clk) cmp = 16'd3;
    base = irq_seen;
    toggle(65525);
    settle();
    chk("R10 at max", count, 65535);
    toggle(1);
    settle();
    chk("R10 rolled to 0", count, 0);
    chk("R10 no irq on roll", irq_seen - base, 0);
    toggle(3);
    settle();
    chk("R10 match after roll", count, 0);
    chk("R10 irq after roll", irq_seen - base, 1);
  endtask

  initial begin
    checks = 0; errors = 0; irq_seen = 0; finished = 0;
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_none();
    t_filter();
    t_match();
    t_zero_cmp();
    t_run();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule